// File: doc/BRIEF.md
# Palette Colour Encoder with YUV Table Readout

This block turns a stream of 9-bit pixel colour indices into colour values for two output paths. A 512-entry palette RAM holds one 9-bit RGB colour per index, with three bits per channel. The palette entry read for a pixel drives the three 3-bit RGB outputs directly. The same entry is also the address of a fixed 512-word conversion table, and each 15-bit table word drives three 5-bit luminance and colour-difference outputs. The only way to reach the table is through the palette output, so a table value is the result of two lookups in a row.

A CPU loads and reads the palette through four byte registers. Any CPU access to the data registers takes the palette away from the pixel stream for that cycle. During blanking, both output paths show black.

Two test pins change what the CPU read path returns. The route pin replaces palette data with conversion-table data. The half pin selects the lower byte or the upper, zero-padded byte of the 15-bit table word. No register can change either selection. Both pins pass through AND gates driven by a common gate input, and that input forces normal mode when it is low.

Top module: `pyx_encoder`

## Requirements
- R1: After reset: the RGB outputs are 0, the YUV outputs hold the black word (Y 0, U 16, V 16), and cpu_rdata is 0.
- R2: A CPU write (cpu_sel=1, cpu_wr=1) works by register code. Code 0 loads index bits 7..0. Code 1 loads index bit 8 from cpu_wdata[0]. Code 2 stages the low data byte. Code 3 stores {cpu_wdata[0], staged byte} into the palette at the current index. A palette entry holds red in bits 8..6, green in 5..3 and blue in 2..0.
- R3: A CPU read (cpu_sel=1, cpu_wr=0) of code 2 returns entry bits 7..0. A read of code 3 returns {7'b0, entry bit 8}. cpu_rdata takes the value on the second rising edge after the read and holds it until the next data read.
- R4: When pix_active=1, the RGB outputs show palette[pix_idx] on the second rising edge after pix_idx is applied.
- R5: In the same cycle as R4, the YUV outputs show T[palette[pix_idx]]. The table word packs Y in bits 14..10, U in 9..5 and V in 4..0. For channel values r,g,b in 0..7:
  - Y = ((77r+150g+29b)*31+896)/1792
  - U = ((128b-43r-85g+896)*31+896)/1792
  - V = ((128r-107g-21b+896)*31+896)/1792
  
  All divisions are integer divisions.
- R6: When pix_active=0, the RGB outputs for that pixel are 0 and the YUV outputs are the black word.
- R7: In a cycle with a CPU access to code 2 or 3, the pixel index is ignored. The palette is read at the CPU index, and that pixel slot shows palette[CPU index].
- R8: When tst_route=1 and tst_gate=1, a data read returns one half of T[palette[index]] instead of palette data. The half is the same for codes 2 and 3.
- R9: When routed, tst_half=0 selects table bits 7..0, and tst_half=1 selects {1'b0, table bits 14..8}.
- R10: When tst_gate=0, tst_route and tst_half are ignored and reads return palette data as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_idx | input | 9 | Pixel colour index from the display controller |
| pix_active | input | 1 | 1 = visible pixel, 0 = blanking |
| cpu_sel | input | 1 | CPU access strobe for this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Register code (0..3) |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte |
| tst_gate | input | 1 | Common enable for the test-pin gates |
| tst_route | input | 1 | Test pin: return table data to the CPU |
| tst_half | input | 1 | Test pin: select the upper table half |
| rgb_r | output | 3 | Red |
| rgb_g | output | 3 | Green |
| rgb_b | output | 3 | Blue |
| yuv_y | output | 5 | Luminance |
| yuv_u | output | 5 | Blue colour difference |
| yuv_v | output | 5 | Red colour difference |

## Verification
Every result of this block is due two rising edges after its stimulus. That covers the RGB and YUV outputs for a pixel index and cpu_rdata for a data-register read. The bench drives on falling edges and samples two falling edges later. In the pixel sweep it keeps a two-deep history, so each output is compared with the stimulus it belongs to. The priority case checks the slot in which the CPU read was presented, and then the slot after it, which must show the pixel index again. The held value of cpu_rdata is checked against the read two slots earlier.

// File: rtl/pyx_pkg.sv
// Shared widths, CPU register codes and the RGB-to-YUV conversion.
// Assumes three equal colour channels in both the palette and the table.
package pyx_pkg;
    localparam int RGB_CH_W = 3;
    localparam int YUV_CH_W = 5;
    localparam int PAL_W    = 3 * RGB_CH_W;
    localparam int YUV_W    = 3 * YUV_CH_W;

    typedef enum logic [1:0] {
        REG_IDX_LO = 2'd0,
        REG_IDX_HI = 2'd1,
        REG_DAT_LO = 2'd2,
        REG_DAT_HI = 2'd3
    } cpu_reg_e;

    // Fixed table content: a pure function of the palette colour, folds to ROM.
    function automatic logic [YUV_W-1:0] yuv_of(input logic [PAL_W-1:0] c);
        int r, g, b, m, t, half, den, y, u, v;
        r    = 32'(c[PAL_W-1 -: RGB_CH_W]);
        g    = 32'(c[2*RGB_CH_W-1 -: RGB_CH_W]);
        b    = 32'(c[RGB_CH_W-1:0]);
        m    = (1 << RGB_CH_W) - 1;
        t    = (1 << YUV_CH_W) - 1;
        half = 128 * m;
        den  = 256 * m;
        y = ((77 * r + 150 * g + 29 * b) * t + half) / den;
        u = ((128 * b - 43 * r - 85 * g + half) * t + half) / den;
        v = ((128 * r - 107 * g - 21 * b + half) * t + half) / den;
        return {y[YUV_CH_W-1:0], u[YUV_CH_W-1:0], v[YUV_CH_W-1:0]};
    endfunction

    localparam logic [YUV_W-1:0] YUV_BLACK = yuv_of('0);
endpackage

// File: rtl/pyx_cpu_port.sv
// CPU register file and palette arbitration.
// Holds the palette index and the staged low data byte, and picks the
// palette address. A data-register access takes the address from the pixel
// stream. Assumes at most one CPU access per cycle.
module pyx_cpu_port
    import pyx_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_reg,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [IDX_W-1:0] ram_addr,
    output logic             ram_we,
    output logic [PAL_W-1:0] ram_wdata,
    output logic             rd_req,
    output logic             rd_hi
);
    localparam int IDX_HI_W = IDX_W - DW;
    localparam int PAL_HI_W = PAL_W - DW;

    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    stage_q;
    logic             wr_acc;
    logic             data_acc;

    assign wr_acc   = cpu_sel & cpu_wr;
    assign data_acc = cpu_sel & cpu_reg[1];

    // Index register, loaded a byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_acc && cpu_reg == REG_IDX_LO) begin
            idx_q[DW-1:0] <= cpu_wdata;
        end else if (wr_acc && cpu_reg == REG_IDX_HI) begin
            idx_q[IDX_W-1:DW] <= cpu_wdata[IDX_HI_W-1:0];
        end
    end

    // Low data byte, held until the high byte commits the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_acc && cpu_reg == REG_DAT_LO) begin
            stage_q <= cpu_wdata;
        end
    end

    // Arbitration: the CPU wins whenever it touches the data registers.
    always_comb begin
        ram_addr  = data_acc ? idx_q : pix_idx;
        ram_we    = wr_acc && cpu_reg == REG_DAT_HI;
        ram_wdata = {cpu_wdata[PAL_HI_W-1:0], stage_q};
        rd_req    = cpu_sel & ~cpu_wr & cpu_reg[1];
        rd_hi     = cpu_reg[0];
    end
endmodule

// File: rtl/pyx_palette_ram.sv
// Single-port palette RAM with one registered read per cycle.
// A write and a read in the same cycle return the old entry. The array has no
// reset; only the read register does.
module pyx_palette_ram
    import pyx_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [PAL_W-1:0] wdata,
    output logic [PAL_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PAL_W-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Registered read of the arbitrated address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/pyx_test_mux.sv
// Gated test selects and the two-stage read-data multiplexer.
// Stage A picks a byte-sized half of the table word, padding the upper half
// with zeros. Stage B picks between palette data and that half.
// Assumes the table word is wider than one byte and no wider than two.
module pyx_test_mux
    import pyx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             gate,
    input  logic             route_pin,
    input  logic             half_pin,
    input  logic             hi_sel,
    input  logic [PAL_W-1:0] pal_entry,
    input  logic [YUV_W-1:0] tbl_word,
    output logic [DW-1:0]    rd_byte
);
    localparam int UP_W  = YUV_W - DW;
    localparam int PHI_W = PAL_W - DW;

    logic          sel_route;
    logic          sel_half;
    logic [DW-1:0] tbl_lo;
    logic [DW-1:0] tbl_hi;
    logic [DW-1:0] pal_byte;
    logic [DW-1:0] tbl_byte;

    // Gated test-pin buffering: a low gate forces normal mode.
    assign sel_route = route_pin & gate;
    assign sel_half  = half_pin & gate;

    assign tbl_lo = tbl_word[DW-1:0];

    // Upper half of the table word, zero padded or trimmed to one byte.
    generate
        if (UP_W < DW) begin : g_pad
            assign tbl_hi = {{(DW - UP_W){1'b0}}, tbl_word[YUV_W-1:DW]};
        end else begin : g_full
            assign tbl_hi = tbl_word[DW +: DW];
        end
    endgenerate

    // Stage A: half select. Stage B: palette or table.
    always_comb begin
        pal_byte = hi_sel ? {{(DW - PHI_W){1'b0}}, pal_entry[PAL_W-1:DW]}
                          : pal_entry[DW-1:0];
        tbl_byte = sel_half ? tbl_hi : tbl_lo;
        rd_byte  = sel_route ? tbl_byte : pal_byte;
    end
endmodule

// File: rtl/pyx_encoder.sv
// Top level of the palette colour encoder.
// Stage 1 reads the palette. Stage 2 runs the table lookup on the palette
// output and registers the RGB, YUV and CPU read results together, so every
// result is due two edges after its stimulus.
module pyx_encoder
    import pyx_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    pix_idx,
    input  logic                pix_active,
    input  logic                cpu_sel,
    input  logic                cpu_wr,
    input  logic [1:0]          cpu_reg,
    input  logic [DW-1:0]       cpu_wdata,
    output logic [DW-1:0]       cpu_rdata,
    input  logic                tst_gate,
    input  logic                tst_route,
    input  logic                tst_half,
    output logic [RGB_CH_W-1:0] rgb_r,
    output logic [RGB_CH_W-1:0] rgb_g,
    output logic [RGB_CH_W-1:0] rgb_b,
    output logic [YUV_CH_W-1:0] yuv_y,
    output logic [YUV_CH_W-1:0] yuv_u,
    output logic [YUV_CH_W-1:0] yuv_v
);
    logic [IDX_W-1:0] ram_addr;
    logic             ram_we;
    logic [PAL_W-1:0] ram_wdata;
    logic [PAL_W-1:0] pal_q;
    logic             rd_req;
    logic             rd_hi;
    logic             rd1_q;
    logic             hi1_q;
    logic             act1_q;
    logic [YUV_W-1:0] tbl_w;
    logic [DW-1:0]    rd_byte;
    logic [PAL_W-1:0] rgb_q;
    logic [YUV_W-1:0] yuv_q;

    pyx_cpu_port #(.IDX_W(IDX_W), .DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_sel   (cpu_sel),
        .cpu_wr    (cpu_wr),
        .cpu_reg   (cpu_reg),
        .cpu_wdata (cpu_wdata),
        .pix_idx   (pix_idx),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .rd_req    (rd_req),
        .rd_hi     (rd_hi)
    );

    pyx_palette_ram #(.IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (pal_q)
    );

    // Table lookup addressed only by the palette output.
    assign tbl_w = yuv_of(pal_q);

    pyx_test_mux #(.DW(DW)) u_tmux (
        .gate      (tst_gate),
        .route_pin (tst_route),
        .half_pin  (tst_half),
        .hi_sel    (hi1_q),
        .pal_entry (pal_q),
        .tbl_word  (tbl_w),
        .rd_byte   (rd_byte)
    );

    // Stage-1 control: read request, byte select and blanking state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd1_q  <= 1'b0;
            hi1_q  <= 1'b0;
            act1_q <= 1'b0;
        end else begin
            rd1_q  <= rd_req;
            hi1_q  <= rd_hi;
            act1_q <= pix_active;
        end
    end

    // Stage-2 colour outputs, black during blanking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_q <= '0;
            yuv_q <= YUV_BLACK;
        end else begin
            rgb_q <= act1_q ? pal_q : '0;
            yuv_q <= act1_q ? tbl_w : YUV_BLACK;
        end
    end

    // Stage-2 CPU read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata <= '0;
        end else if (rd1_q) begin
            cpu_rdata <= rd_byte;
        end
    end

    assign rgb_r = rgb_q[PAL_W-1 -: RGB_CH_W];
    assign rgb_g = rgb_q[2*RGB_CH_W-1 -: RGB_CH_W];
    assign rgb_b = rgb_q[RGB_CH_W-1:0];
    assign yuv_y = yuv_q[YUV_W-1 -: YUV_CH_W];
    assign yuv_u = yuv_q[2*YUV_CH_W-1 -: YUV_CH_W];
    assign yuv_v = yuv_q[YUV_CH_W-1:0];
endmodule

// File: rtl/pyx_encoder_sva.sv
// Port-level assertions for pyx_encoder, attached with bind.
// A small warm-up counter keeps every two-cycle look-back inside the reset
// history.
module pyx_encoder_sva
    import pyx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_sel,
    input logic                cpu_wr,
    input logic [1:0]          cpu_reg,
    input logic                pix_active,
    input logic                tst_gate,
    input logic                tst_route,
    input logic                tst_half,
    input logic [DW-1:0]       cpu_rdata,
    input logic [RGB_CH_W-1:0] rgb_r,
    input logic [RGB_CH_W-1:0] rgb_g,
    input logic [RGB_CH_W-1:0] rgb_b,
    input logic [YUV_CH_W-1:0] yuv_y,
    input logic [YUV_CH_W-1:0] yuv_u,
    input logic [YUV_CH_W-1:0] yuv_v
);
    logic [1:0] warm_q;
    logic       rd_now;
    logic       routed;

    assign rd_now = cpu_sel & ~cpu_wr & cpu_reg[1];
    assign routed = tst_route & tst_gate;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R3: read data holds unless a data read came two cycles earlier.
    a_r3_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && !$past(rd_now, 2)) |-> $stable(cpu_rdata));

    // R6: a blanked pixel comes out black on both paths.
    a_r6_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && !$past(pix_active, 2)) |->
        ({rgb_r, rgb_g, rgb_b} == '0 && {yuv_y, yuv_u, yuv_v} == YUV_BLACK));

    // R3 and R10: a normal high-byte read carries only bit 8 of the entry.
    a_r10_normal_hi_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(rd_now, 2) && $past(cpu_reg[0], 2) && !$past(routed, 2))
        |-> (cpu_rdata[DW-1:1] == '0));

    // R9: the upper table half has its top bit padded with zero.
    a_r9_upper_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && $past(rd_now, 2) && $past(routed, 2) && $past(tst_half & tst_gate, 2))
        |-> (cpu_rdata[DW-1] == 1'b0));
endmodule

bind pyx_encoder pyx_encoder_sva #(.DW(DW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_reg    (cpu_reg),
    .pix_active (pix_active),
    .tst_gate   (tst_gate),
    .tst_route  (tst_route),
    .tst_half   (tst_half),
    .cpu_rdata  (cpu_rdata),
    .rgb_r      (rgb_r),
    .rgb_g      (rgb_g),
    .rgb_b      (rgb_b),
    .yuv_y      (yuv_y),
    .yuv_u      (yuv_u),
    .yuv_v      (yuv_v)
);

// File: tb/pyx_encoder_tb.sv
// Exhaustive bench: loads every palette entry, reads each one back, sweeps
// every index through the pixel path and reads every table half in test mode.
module pyx_encoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] pix_idx = '0;
    logic       pix_active = 1'b0;
    logic       cpu_sel = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_reg = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tst_gate = 1'b1;
    logic       tst_route = 1'b0;
    logic       tst_half = 1'b0;
    logic [2:0] rgb_r, rgb_g, rgb_b;
    logic [4:0] yuv_y, yuv_u, yuv_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] pal [512];

    always #10 clk = ~clk;

    pyx_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .pix_idx(pix_idx), .pix_active(pix_active),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_reg(cpu_reg),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tst_gate(tst_gate),
        .tst_route(tst_route), .tst_half(tst_half), .rgb_r(rgb_r),
        .rgb_g(rgb_g), .rgb_b(rgb_b), .yuv_y(yuv_y), .yuv_u(yuv_u),
        .yuv_v(yuv_v)
    );

    // Expected table word from the formulas in the requirements.
    function automatic logic [14:0] exp_yuv(input logic [8:0] c);
        int r, g, b, y, u, v;
        r = 32'(c[8:6]); g = 32'(c[5:3]); b = 32'(c[2:0]);
        y = ((77 * r + 150 * g + 29 * b) * 31 + 896) / 1792;
        u = ((128 * b - 43 * r - 85 * g + 896) * 31 + 896) / 1792;
        v = ((128 * r - 107 * g - 21 * b + 896) * 31 + 896) / 1792;
        return {y[4:0], u[4:0], v[4:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic cpu_write(input logic [1:0] r, input logic [7:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_reg = r; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic set_index(input logic [8:0] i);
        cpu_write(2'd0, i[7:0]);
        cpu_write(2'd1, {7'b0, i[8]});
    endtask

    task automatic cpu_read(input logic [1:0] r, output logic [7:0] d);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_reg = r;
        @(negedge clk);
        cpu_sel = 1'b0;
        @(negedge clk);
        d = cpu_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [8:0] hist_idx [2];
        logic       hist_act [2];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rgb", {rgb_r, rgb_g, rgb_b}, 0);
        check("R1 yuv", {yuv_y, yuv_u, yuv_v}, {5'd0, 5'd16, 5'd16});
        check("R1 rdata", cpu_rdata, 0);

        // R2: load every palette entry
        for (int i = 0; i < 512; i++) begin
            pal[i] = 9'((i * 37 + 5) ^ (i >> 3));
            set_index(9'(i));
            cpu_write(2'd2, pal[i][7:0]);
            cpu_write(2'd3, {7'b0, pal[i][8]});
        end

        // R2/R3: read back both bytes of every entry
        for (int i = 0; i < 512; i++) begin
            set_index(9'(i));
            cpu_read(2'd2, d);
            check("R2 R3 low byte", d, pal[i][7:0]);
            cpu_read(2'd3, d);
            check("R3 high byte", d, {7'b0, pal[i][8]});
        end
        // R3: held value after idle cycles
        repeat (3) @(negedge clk);
        check("R3 hold", cpu_rdata, {7'b0, pal[511][8]});

        // R4/R5/R6: pixel sweep, two-cycle latency with blanking mixed in
        for (int k = 0; k < 514; k++) begin
            if (k >= 2) begin
                logic [8:0] e;
                e = hist_act[0] ? pal[hist_idx[0]] : 9'd0;
                check("R4 R6 rgb", {rgb_r, rgb_g, rgb_b}, e);
                check("R5 R6 yuv", {yuv_y, yuv_u, yuv_v},
                      hist_act[0] ? exp_yuv(pal[hist_idx[0]]) : exp_yuv(9'd0));
            end
            hist_idx[0] = hist_idx[1]; hist_act[0] = hist_act[1];
            if (k < 512) begin
                pix_idx = 9'(k); pix_active = (k % 7) != 3;
            end
            hist_idx[1] = pix_idx; hist_act[1] = pix_active;
            @(negedge clk);
        end

        // R7: CPU read steals the palette from the pixel stream
        set_index(9'd100);
        pix_idx = 9'd200; pix_active = 1'b1;
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_reg = 2'd2;
        @(negedge clk);
        cpu_sel = 1'b0;
        @(negedge clk);
        check("R7 stolen slot", {rgb_r, rgb_g, rgb_b}, pal[100]);
        check("R7 cpu data", cpu_rdata, pal[100][7:0]);
        @(negedge clk);
        check("R7 next slot", {rgb_r, rgb_g, rgb_b}, pal[200]);

        // R8/R9: table readout through the palette, both halves, both codes
        tst_gate = 1'b1; tst_route = 1'b1;
        for (int i = 0; i < 512; i++) begin
            logic [14:0] w;
            w = exp_yuv(pal[i]);
            set_index(9'(i));
            tst_half = 1'b0;
            cpu_read(2'd2, d);
            check("R8 R9 lower half", d, w[7:0]);
            tst_half = 1'b1;
            cpu_read(2'd3, d);
            check("R8 R9 upper half", d, {1'b0, w[14:8]});
            if (i % 64 == 0) begin
                cpu_read(2'd2, d);
                check("R8 code independent", d, {1'b0, w[14:8]});
            end
        end
        // R8: pixel path keeps showing palette colour while routed
        pix_idx = 9'd77; pix_active = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 rgb unaffected", {rgb_r, rgb_g, rgb_b}, pal[77]);

        // R10: gate low forces normal reads
        tst_gate = 1'b0; tst_route = 1'b1; tst_half = 1'b1;
        for (int i = 0; i < 512; i += 17) begin
            set_index(9'(i));
            cpu_read(2'd2, d);
            check("R10 gated low", d, pal[i][7:0]);
            cpu_read(2'd3, d);
            check("R10 gated high", d, {7'b0, pal[i][8]});
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule